// File: doc/BRIEF.md
# Octal DAC Register and Update Controller

This block is the digital register file and update logic that sits in front of an eight-channel, 8-bit digital-to-analogue converter. A host writes 12-bit words through a parallel port made of a 4-bit address, a data word and a one-cycle write strobe. Each channel has an input register and an output register. The input register takes the new code. The output register copies it across on every clock edge where the active-low load pin is low, so a host can stage several channels and then release them together. If it holds the load pin low, every write takes effect without a separate update step.

The block also holds a global control word (power-down, data-out enable, reference select, input format) and a per-pair control word (power-down and speed flag for each of the four channel pairs). A preset register feeds all eight outputs at once while the asynchronous active-low preset pin is low. Four paired-write addresses store a code in the first channel of a pair and its bitwise complement in the second. When two's-complement input is selected, every incoming code is turned into straight binary before it is stored.

Top module: `octal_dac_regctl`

## Requirements
- R1: A write to address 0..7 stores bits 11:4 of the data word as the code of channel A..H (channel n at `dac_code[8n+7:8n]`). Bits 3:0 are ignored.
- R2: A channel output takes the value of its input register on each clock edge where `load_n` is low, and holds its value on edges where `load_n` is high. A write captured on edge t can reach the output on edge t+1 at the earliest.
- R3: A write to address 8 sets `twos_mode` from bit 0, `ref_sel` from bits 2:1, `dout_en` from bit 3 and `pwr_down_all` from bit 4. Bits 11:5 have no effect.
- R4: A write to address 9 sets `pair_fast[p]` from bit p and `pair_pd[p]` from bit 4+p, where pair 0 is AB, 1 is CD, 2 is EF and 3 is GH. Bits 11:8 have no effect.
- R5: A write to address 10 stores the code in the preset register. While `preset_n` is low, all eight channel outputs show the preset code with no clock edge needed.
- R6: After reset, and until address 10 is written, asserting `preset_n` drives every channel to 0.
- R7: A write to address 12, 13, 14 or 15 stores the code in channel A, C, E or G and its bitwise complement in channel B, D, F or H, both on the same clock edge.
- R8: While `twos_mode` is 1 (the value held before the write), the most significant bit of the code is inverted before it is stored. This applies to channel, paired and preset writes. For a paired write the inversion happens before the complement is formed.
- R9: A write to address 11 changes no register and no output.
- R10: A clock edge with `rst` high clears all input, output, preset and control registers to 0.
- R11: The load path keeps running while `preset_n` is low. When `preset_n` goes high, the outputs show the current output registers at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Write data word |
| load_n | input | 1 | Active-low transfer enable from input to output registers |
| preset_n | input | 1 | Asynchronous active-low preset override |
| dac_code | output | 64 | Eight 8-bit channel codes, channel A in the lowest byte |
| pwr_down_all | output | 1 | Full power-down flag |
| dout_en | output | 1 | Data-out enable flag |
| ref_sel | output | 2 | Reference select field |
| twos_mode | output | 1 | 1 = two's-complement input format |
| pair_pd | output | 4 | Per-pair power-down flags, bit 0 = AB |
| pair_fast | output | 4 | Per-pair speed flags, bit 0 = AB |

## Verification
A wrong input register is hidden until `load_n` goes low. After that it appears on `dac_code` one edge later, so the bench compares every channel against a behavioural model on every cycle under random load timing, to expose staged values as soon as they are transferred. A corrupted preset register or a bad output mux appears at once when `preset_n` drops, without waiting for a clock. For that reason preset assertion and release are checked in the middle of a cycle. Wrong control registers show on the flag outputs on the first cycle after the write.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

  // Global control word, laid out so that bit 0 of the write data is the
  // input-format bit and bit 4 is full power-down.
  typedef struct packed {
    logic       pwr_down;
    logic       dout_en;
    logic [1:0] ref_sel;
    logic       twos;
  } glb_ctrl_t;

  localparam int GLB_CTRL_W = $bits(glb_ctrl_t);

endpackage

// File: rtl/octdac_wr_decode.sv
module octdac_wr_decode #(
  parameter int NCH    = 8,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [CODE_W-1:0]     code_in,
  input  logic                  twos_mode,
  output logic [NCH-1:0]        ch_we,
  output logic [NCH*CODE_W-1:0] ch_wdata,
  output logic                  glb_we,
  output logic                  pctl_we,
  output logic                  preset_we,
  output logic [CODE_W-1:0]     norm_code
);
  localparam int NPAIR    = NCH / 2;
  localparam int A_GLB    = NCH;
  localparam int A_PCTL   = NCH + 1;
  localparam int A_PRESET = NCH + 2;
  localparam int A_PAIR0  = NCH + 4;
  localparam logic [CODE_W-1:0] MSB_MASK = {1'b1, {(CODE_W-1){1'b0}}};

  // Format conversion: offset binary is two's complement with the sign flipped
  always_comb begin
    norm_code = code_in;
    if (twos_mode) norm_code = code_in ^ MSB_MASK;
  end

  assign glb_we    = wr_en && (wr_addr == ADDR_W'(A_GLB));
  assign pctl_we   = wr_en && (wr_addr == ADDR_W'(A_PCTL));
  assign preset_we = wr_en && (wr_addr == ADDR_W'(A_PRESET));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int PAIR = ch / 2;
    logic hit_direct;
    logic hit_pair;
    assign hit_direct = wr_en && (wr_addr == ADDR_W'(ch));
    assign hit_pair   = wr_en && (wr_addr == ADDR_W'(A_PAIR0 + PAIR)) && (PAIR < NPAIR);
    assign ch_we[ch]  = hit_direct || hit_pair;
    if ((ch % 2) == 1) begin : g_second
      assign ch_wdata[ch*CODE_W +: CODE_W] = hit_pair ? ~norm_code : norm_code;
    end else begin : g_first
      assign ch_wdata[ch*CODE_W +: CODE_W] = norm_code;
    end
  end

endmodule

// File: rtl/octdac_ctrl_regs.sv
module octdac_ctrl_regs
  import octdac_pkg::*;
#(
  parameter int NPAIR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_we,
  input  logic               pctl_we,
  input  logic [2*NPAIR-1:0] ctrl_in,
  output glb_ctrl_t          glb_q,
  output logic [NPAIR-1:0]   pair_pd,
  output logic [NPAIR-1:0]   pair_fast
);
  localparam int PCTL_W = 2 * NPAIR;

  logic [PCTL_W-1:0] pctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_q <= '0;
    end else if (glb_we) begin
      glb_q <= glb_ctrl_t'(ctrl_in[GLB_CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pctl_q <= '0;
    end else if (pctl_we) begin
      pctl_q <= ctrl_in;
    end
  end

  assign pair_fast = pctl_q[NPAIR-1:0];
  assign pair_pd   = pctl_q[PCTL_W-1:NPAIR];

endmodule

// File: rtl/octdac_chan_bank.sv
module octdac_chan_bank #(
  parameter int NCH    = 8,
  parameter int CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        ch_we,
  input  logic [NCH*CODE_W-1:0] ch_wdata,
  input  logic                  load_n,
  output logic [NCH*CODE_W-1:0] in_flat,
  output logic [NCH*CODE_W-1:0] out_flat
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CODE_W-1:0] in_q;
    logic [CODE_W-1:0] out_q;

    // Stage 1: host-facing input register
    always_ff @(posedge clk) begin
      if (rst) begin
        in_q <= '0;
      end else if (ch_we[ch]) begin
        in_q <= ch_wdata[ch*CODE_W +: CODE_W];
      end
    end

    // Stage 2: converter-facing register, gated by the load pin
    always_ff @(posedge clk) begin
      if (rst) begin
        out_q <= '0;
      end else if (!load_n) begin
        out_q <= in_q;
      end
    end

    assign in_flat[ch*CODE_W +: CODE_W]  = in_q;
    assign out_flat[ch*CODE_W +: CODE_W] = out_q;
  end

endmodule

// File: rtl/octal_dac_regctl.sv
module octal_dac_regctl
  import octdac_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CODE_W = 8,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  load_n,
  input  logic                  preset_n,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic                  pwr_down_all,
  output logic                  dout_en,
  output logic [1:0]            ref_sel,
  output logic                  twos_mode,
  output logic [NCH/2-1:0]      pair_pd,
  output logic [NCH/2-1:0]      pair_fast
);
  localparam int NPAIR = NCH / 2;

  logic [NCH-1:0]        ch_we;
  logic [NCH*CODE_W-1:0] ch_wdata;
  logic                  glb_we;
  logic                  pctl_we;
  logic                  preset_we;
  logic [CODE_W-1:0]     norm_code;
  logic [NCH*CODE_W-1:0] in_flat;
  logic [NCH*CODE_W-1:0] out_flat;
  logic [CODE_W-1:0]     preset_q;
  glb_ctrl_t             glb_q;

  octdac_wr_decode #(
    .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .code_in   (wr_data[DATA_W-1 -: CODE_W]),
    .twos_mode (glb_q.twos),
    .ch_we     (ch_we),
    .ch_wdata  (ch_wdata),
    .glb_we    (glb_we),
    .pctl_we   (pctl_we),
    .preset_we (preset_we),
    .norm_code (norm_code)
  );

  octdac_ctrl_regs #(
    .NPAIR(NPAIR)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .glb_we    (glb_we),
    .pctl_we   (pctl_we),
    .ctrl_in   (wr_data[2*NPAIR-1:0]),
    .glb_q     (glb_q),
    .pair_pd   (pair_pd),
    .pair_fast (pair_fast)
  );

  octdac_chan_bank #(
    .NCH(NCH), .CODE_W(CODE_W)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .ch_we    (ch_we),
    .ch_wdata (ch_wdata),
    .load_n   (load_n),
    .in_flat  (in_flat),
    .out_flat (out_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      preset_q <= '0;
    end else if (preset_we) begin
      preset_q <= norm_code;
    end
  end

  // Asynchronous override: the preset pin selects without a clock
  assign dac_code     = preset_n ? out_flat : {NCH{preset_q}};
  assign pwr_down_all = glb_q.pwr_down;
  assign dout_en      = glb_q.dout_en;
  assign ref_sel      = glb_q.ref_sel;
  assign twos_mode    = glb_q.twos;

endmodule

// File: rtl/octdac_checker.sv
module octdac_checker #(
  parameter int NCH    = 8,
  parameter int CODE_W = 8,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [DATA_W-1:0]     wr_data,
  input logic                  load_n,
  input logic                  preset_n,
  input logic [NCH*CODE_W-1:0] dac_code,
  input logic                  pwr_down_all,
  input logic                  dout_en,
  input logic [1:0]            ref_sel,
  input logic                  twos_mode,
  input logic [NCH/2-1:0]      pair_pd,
  input logic [NCH/2-1:0]      pair_fast,
  input logic [NCH*CODE_W-1:0] in_flat,
  input logic [NCH*CODE_W-1:0] out_flat,
  input logic [CODE_W-1:0]     preset_q
);
  localparam int NPAIR    = NCH / 2;
  localparam int A_GLB    = NCH;
  localparam int A_PRESET = NCH + 2;
  localparam int A_VOID   = NCH + 3;
  localparam int A_PAIR0  = NCH + 4;
  localparam logic [CODE_W-1:0] MSB_MASK = {1'b1, {(CODE_W-1){1'b0}}};

  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_flat == '0 && out_flat == '0 && preset_q == '0 &&
                    pair_pd == '0 && pair_fast == '0 && pwr_down_all == 1'b0 &&
                    dout_en == 1'b0 && ref_sel == 2'b00 && twos_mode == 1'b0));

  assert_load_hold_R2: assert property (@(posedge clk) disable iff (rst)
    load_n |=> $stable(out_flat));

  assert_glb_fields_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(A_GLB)) |=>
      {pwr_down_all, dout_en, ref_sel, twos_mode} == $past(wr_data[4:0]));

  assert_preset_value_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_addr == ADDR_W'(A_PRESET)) && !preset_n) |->
      dac_code[CODE_W-1:0] ==
        ($past(wr_data[DATA_W-1 -: CODE_W]) ^ ($past(twos_mode) ? MSB_MASK : '0)));

  for (genvar ch = 1; ch < NCH; ch++) begin : g_uni
    assert_preset_uniform_R5: assert property (@(posedge clk) disable iff (rst)
      !preset_n |-> dac_code[ch*CODE_W +: CODE_W] == dac_code[CODE_W-1:0]);
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assert_pair_compl_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(A_PAIR0 + p)) |=>
        in_flat[(2*p)*CODE_W +: CODE_W] == ~in_flat[(2*p+1)*CODE_W +: CODE_W]);
  end

  assert_twos_conv_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0 && twos_mode) |=>
      in_flat[CODE_W-1:0] == ($past(wr_data[DATA_W-1 -: CODE_W]) ^ MSB_MASK));

  assert_void_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(A_VOID)) |=>
      ($stable(in_flat) && $stable(preset_q) && $stable(pair_pd) && $stable(pair_fast) &&
       $stable({pwr_down_all, dout_en, ref_sel, twos_mode})));

  // R11: while preset is released the outputs track the load-gated registers
  assert_release_track_R11: assert property (@(posedge clk) disable iff (rst)
    preset_n |-> dac_code == out_flat);

endmodule

bind octal_dac_regctl octdac_checker #(
  .NCH(NCH), .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .load_n       (load_n),
  .preset_n     (preset_n),
  .dac_code     (dac_code),
  .pwr_down_all (pwr_down_all),
  .dout_en      (dout_en),
  .ref_sel      (ref_sel),
  .twos_mode    (twos_mode),
  .pair_pd      (pair_pd),
  .pair_fast    (pair_fast),
  .in_flat      (in_flat),
  .out_flat     (out_flat),
  .preset_q     (preset_q)
);

// File: tb/octal_dac_regctl_tb.sv
module octal_dac_regctl_tb;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        load_n = 1'b1;
  logic        preset_n = 1'b1;
  logic [63:0] dac_code;
  logic        pwr_down_all, dout_en, twos_mode;
  logic [1:0]  ref_sel;
  logic [3:0]  pair_pd, pair_fast;

  int n_chk = 0;
  int n_fail = 0;
  bit model_ok = 1'b0;
  bit done = 1'b0;

  logic [7:0] in_m [NCH];
  logic [7:0] out_m [NCH];
  logic [7:0] preset_m;
  logic [4:0] glb_m;
  logic [7:0] pctl_m;

  always #4 clk = ~clk;

  octal_dac_regctl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_n(load_n), .preset_n(preset_n), .dac_code(dac_code),
    .pwr_down_all(pwr_down_all), .dout_en(dout_en), .ref_sel(ref_sel),
    .twos_mode(twos_mode), .pair_pd(pair_pd), .pair_fast(pair_fast)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ch(input int i);
    return dac_code[i*8 +: 8];
  endfunction

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin in_m[i] = '0; out_m[i] = '0; end
      preset_m = '0; glb_m = '0; pctl_m = '0;
      model_ok = 1'b1;
    end else begin
      logic [7:0] code;
      for (int i = 0; i < NCH; i++) if (!load_n) out_m[i] = in_m[i];
      if (wr_en) begin
        code = wr_data[11:4];
        if (glb_m[0]) code[7] = ~code[7];
        if (wr_addr < 4'd8) in_m[wr_addr] = code;
        else if (wr_addr == 4'd8) glb_m = wr_data[4:0];
        else if (wr_addr == 4'd9) pctl_m = wr_data[7:0];
        else if (wr_addr == 4'd10) preset_m = code;
        else if (wr_addr >= 4'd12) begin
          in_m[2*(wr_addr-12)]   = code;
          in_m[2*(wr_addr-12)+1] = ~code;
        end
      end
    end
  end

  // Cycle compare away from the active edge
  always @(negedge clk) begin
    if (model_ok && !done) begin
      for (int i = 0; i < NCH; i++)
        check("R1/R2/R5/R7/R8/R11 model dac", {24'h0, ch(i)},
              {24'h0, (preset_n ? out_m[i] : preset_m)});
      check("R3 model glb", {27'h0, pwr_down_all, dout_en, ref_sel, twos_mode}, {27'h0, glb_m});
      check("R4 model pair", {24'h0, pair_pd, pair_fast}, {24'h0, pctl_m});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
  end

  initial begin
    logic [63:0] snap;
    logic [11:0] snap_ctl;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R10 reset dac", dac_code[31:0], 32'h0);
    check("R10 reset dac hi", dac_code[63:32], 32'h0);
    check("R10 reset ctl", {20'h0, pwr_down_all, dout_en, ref_sel, twos_mode, pair_pd, pair_fast}, 32'h0);

    @(posedge clk); #1 load_n = 1'b0;
    wr(4'd0, 12'hABF); settle();
    check("R1 low bits ignored", {24'h0, ch(0)}, 32'hAB);

    for (int i = 0; i < NCH; i++) wr(4'(i), {8'(i*17+3), 4'hF});
    settle();
    for (int i = 0; i < NCH; i++) check("R1 channel code", {24'h0, ch(i)}, 32'(i*17+3));

    @(posedge clk); #1 load_n = 1'b1;
    wr(4'd1, 12'h550); settle(); settle();
    check("R2 hold while load high", {24'h0, ch(1)}, 32'h14);
    @(posedge clk); #1 load_n = 1'b0;
    settle();
    check("R2 transfer on load low", {24'h0, ch(1)}, 32'h55);

    @(posedge clk); #1 preset_n = 1'b0; #1;
    for (int i = 0; i < NCH; i++) check("R6 unwritten preset zero", {24'h0, ch(i)}, 32'h0);
    @(posedge clk); #1 preset_n = 1'b1;

    wr(4'd12, 12'hFF0); settle();
    check("R7 pair AB first", {24'h0, ch(0)}, 32'hFF);
    check("R7 pair AB second", {24'h0, ch(1)}, 32'h00);
    wr(4'd15, 12'h3C0); settle();
    check("R7 pair GH", {16'h0, ch(7), ch(6)}, 32'hC33C);

    wr(4'd8, 12'hFFF); settle();
    check("R3 glb fields", {27'h0, pwr_down_all, dout_en, ref_sel, twos_mode}, 32'h1F);
    wr(4'd0, 12'h000); settle();
    check("R8 twos channel", {24'h0, ch(0)}, 32'h80);
    wr(4'd13, 12'h7F0); settle();
    check("R8 twos pair", {16'h0, ch(3), ch(2)}, 32'h00FF);
    wr(4'd10, 12'h000);
    wr(4'd8, 12'h000); settle();
    check("R3 glb cleared", {27'h0, pwr_down_all, dout_en, ref_sel, twos_mode}, 32'h0);

    wr(4'd9, 12'hFA5); settle();
    check("R4 pair pd", {28'h0, pair_pd}, 32'hA);
    check("R4 pair fast", {28'h0, pair_fast}, 32'h5);

    snap = dac_code;
    snap_ctl = {pwr_down_all, dout_en, ref_sel, twos_mode, pair_pd, pair_fast, 1'b0, 1'b0, 1'b0};
    wr(4'd11, 12'hFFF); settle(); settle();
    check("R9 void addr dac lo", dac_code[31:0], snap[31:0]);
    check("R9 void addr dac hi", dac_code[63:32], snap[63:32]);
    check("R9 void addr ctl", {20'h0, pwr_down_all, dout_en, ref_sel, twos_mode, pair_pd, pair_fast, 3'b0},
          {20'h0, snap_ctl});

    @(posedge clk); #1 preset_n = 1'b0; #1;
    for (int i = 0; i < NCH; i++) check("R5 async preset", {24'h0, ch(i)}, 32'h80);
    wr(4'd2, 12'h120); settle();
    check("R11 preset still overrides", {24'h0, ch(2)}, 32'h80);
    #1 preset_n = 1'b1; #1;
    check("R11 release shows load path", {24'h0, ch(2)}, 32'h12);

    for (int k = 0; k < 600; k++) begin
      @(posedge clk); #1;
      load_n   = ($urandom_range(0, 3) != 0) ? 1'b0 : 1'b1;
      preset_n = ($urandom_range(0, 7) != 0);
      wr_en    = ($urandom_range(0, 1) == 1);
      wr_addr  = 4'($urandom_range(0, 15));
      wr_data  = 12'($urandom);
    end
    @(posedge clk); #1 wr_en = 1'b0; preset_n = 1'b1; load_n = 1'b0;
    settle(); settle();

    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R10 second reset", dac_code[31:0] | dac_code[63:32], 32'h0);
    summary();
  end

endmodule